// File: doc/BRIEF.md
# Load-Adaptive Auxiliary Switch Delay Generator

This block produces the turn-off timing for the auxiliary switch of a converter with several switches. Each switching cycle opens with a one-cycle start pulse that arms a delay latch and drives the delayed-PWM flag high. The main PWM command is synchronised into the system clock domain. When it falls, which marks turn-off of a main switch, a ramp counter that has been held at zero starts to count. When the ramp reaches the load-demand word, the latch trips and the delayed flag drops. The auxiliary drive is the delayed flag, gated off while the start pulse is present.

The delay follows the demand word every cycle. A heavy load (large word) holds the auxiliary switch on well past main turn-off. A light load (small word) shortens the overlap. A word of zero removes it entirely, so the minimum controllable duty ratio stays small. A prescaler stretches each ramp step over a programmable number of clock cycles. This sets the time scale of the delay.

Top module: `auxDelayGen`

## Requirements
- R1: After synchronous reset, and until the first cycle-start pulse, `pwmDel` and `auxDrv` are both 0.
- R2: A cycle-start pulse sampled high at a rising edge makes `pwmDel` 1 after that edge and clears the ramp and prescaler. This takes priority over any pending trip.
- R3: `auxDrv` is 1 exactly when `pwmDel` is 1 and `cycleStart` is 0, so it is forced low for the whole start pulse.
- R4: `pwmIn` passes through a two-flop synchroniser. Its falling edge is recognised on the synchronised copy at the third rising edge after `pwmIn` goes low. The fall starts the ramp only while `pwmDel` is 1.
- R5: With `demand` = 0, `pwmDel` goes low at that third rising edge, so the delay adds no cycles.
- R6: With `demand` = D > 0 and `prescale` = p, `pwmDel` goes low at rising edge 3 + D*(p+1) counted from `pwmIn` going low. A larger D gives a proportionally longer delay.
- R7: The 8-bit `prescale` value p gives a ramp tick every p+1 clock cycles, a divide ratio from 1 (p = 0) to 256 (p = 255).
- R8: A cycle-start pulse that arrives before the trip abandons the pending delay. `pwmDel` then stays 1 until a new falling edge of `pwmIn` starts a fresh, full-length delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cycleStart | input | 1 | One-cycle pulse at the start of each switching cycle |
| pwmIn | input | 1 | Main PWM command, asynchronous; a falling edge marks main switch turn-off |
| demand | input | DEMAND_W (8) | Load-demand word; the delay in ramp ticks |
| prescale | input | PRE_W (8) | Ramp tick divider; ratio is value + 1 |
| pwmDel | output | 1 | Delayed PWM flag |
| auxDrv | output | 1 | Auxiliary switch drive |

## Verification
The delay path is run with several pairs of demand word and prescaler value. Zero demand isolates the fixed synchroniser latency. Small and large words at a divide ratio of one separate the step count from the latency. Non-unit ratios, including the maximum of 256, show that the prescaler multiplies the step count and is not added to it. A long delay interrupted by a new start pulse, followed by a short delay in the same setup, shows that the abandoned count leaves nothing behind. Each start pulse also checks the gating of the auxiliary drive while the pulse is high and after it ends.

// File: rtl/auxdly_pkg.sv
package auxdly_pkg;

  // Strobes from control to the ramp datapath
  typedef struct packed {
    logic clear;   // force ramp and prescaler to zero
    logic run;     // ramp released, prescaler counting
  } rampCmd_t;

  // Status from the ramp datapath back to control
  typedef struct packed {
    logic tick;    // prescaler wraps this cycle, ramp steps
    logic reach;   // the step taken this cycle reaches the demand word
    logic zero;    // demand word is zero
  } rampStat_t;

endpackage

// File: rtl/auxRampPath.sv
module auxRampPath
  import auxdly_pkg::*;
#(
  parameter int DEMAND_W = 8,
  parameter int PRE_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  rampCmd_t            cmd,
  input  logic [DEMAND_W-1:0] demand,
  input  logic [PRE_W-1:0]    prescale,
  output rampStat_t           stat
);

  localparam logic [DEMAND_W-1:0] RAMP_MAX = {DEMAND_W{1'b1}};

  logic [PRE_W-1:0]    preCnt;
  logic [DEMAND_W-1:0] ramp;
  logic [DEMAND_W:0]   rampNext;

  assign rampNext   = {1'b0, ramp} + {{DEMAND_W{1'b0}}, 1'b1};
  assign stat.tick  = cmd.run && (preCnt == prescale);
  assign stat.reach = rampNext >= {1'b0, demand};
  assign stat.zero  = (demand == '0);

  always_ff @(posedge clk) begin
    if (rst || cmd.clear) begin
      preCnt <= '0;
      ramp   <= '0;
    end else if (cmd.run) begin
      if (stat.tick) begin
        preCnt <= '0;
        if (ramp != RAMP_MAX) ramp <= rampNext[DEMAND_W-1:0];
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R2
  clear_zeroes_ramp_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.clear |=> (ramp == '0 && preCnt == '0));

  // R6
  ramp_saturates_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp == RAMP_MAX && !cmd.clear) |=> (ramp == RAMP_MAX));

  // R7
  ramp_steps_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd.clear && !stat.tick) |=> $stable(ramp));

endmodule

// File: rtl/auxCtrl.sv
module auxCtrl
  import auxdly_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cycleStart,
  input  logic      pwmIn,
  input  rampStat_t stat,
  output rampCmd_t  cmd,
  output logic      pwmDel
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncPrev;
  logic                   pwmFall;
  logic                   running;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) syncQ[g] <= rst ? 1'b0 : pwmIn;
    end else begin : g_next
      always_ff @(posedge clk) syncQ[g] <= rst ? 1'b0 : syncQ[g-1];
    end
  end

  always_ff @(posedge clk) syncPrev <= rst ? 1'b0 : syncQ[LAST];

  assign pwmFall = syncPrev && !syncQ[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      pwmDel  <= 1'b0;
      running <= 1'b0;
    end else if (cycleStart) begin
      pwmDel  <= 1'b1;
      running <= 1'b0;
    end else if (pwmDel && !running && pwmFall) begin
      if (stat.zero) pwmDel  <= 1'b0;
      else           running <= 1'b1;
    end else if (running && stat.tick && stat.reach) begin
      pwmDel  <= 1'b0;
      running <= 1'b0;
    end
  end

  assign cmd.clear = cycleStart;
  assign cmd.run   = running;

  // R2
  start_arms_latch_chk: assert property (@(posedge clk) disable iff (rst)
    cycleStart |=> pwmDel);

  // R4
  trip_needs_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwmDel) |-> $past(running || pwmFall));

  // R8
  latch_holds_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!pwmDel && !cycleStart) |=> !pwmDel);

endmodule

// File: rtl/auxDelayGen.sv
module auxDelayGen
  import auxdly_pkg::*;
#(
  parameter int DEMAND_W    = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cycleStart,
  input  logic                pwmIn,
  input  logic [DEMAND_W-1:0] demand,
  input  logic [PRE_W-1:0]    prescale,
  output logic                pwmDel,
  output logic                auxDrv
);

  rampCmd_t  rampCmd;
  rampStat_t rampStat;

  auxCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cycleStart (cycleStart),
    .pwmIn      (pwmIn),
    .stat       (rampStat),
    .cmd        (rampCmd),
    .pwmDel     (pwmDel)
  );

  auxRampPath #(.DEMAND_W(DEMAND_W), .PRE_W(PRE_W)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .cmd      (rampCmd),
    .demand   (demand),
    .prescale (prescale),
    .stat     (rampStat)
  );

  assign auxDrv = pwmDel && !cycleStart;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!pwmDel && !auxDrv));

endmodule

// File: tb/test_auxDelayGen.sv
module test_auxDelayGen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cycleStart = 1'b0;
  logic       pwmIn = 1'b0;
  logic [7:0] demand = '0;
  logic [7:0] prescale = '0;
  logic       pwmDel;
  logic       auxDrv;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int expQ[$];
  string tagQ[$];
  bit measuring = 1'b0;
  int mcnt = 0;

  always #2 clk = ~clk;

  auxDelayGen i_auxDelayGen (
    .clk(clk), .rst(rst), .cycleStart(cycleStart), .pwmIn(pwmIn),
    .demand(demand), .prescale(prescale), .pwmDel(pwmDel), .auxDrv(auxDrv)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Monitor: counts negedges from the pwmIn fall and compares against the queue
  always @(negedge clk) begin
    if (measuring) begin
      mcnt++;
      if (!pwmDel) begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(mcnt == e, t, mcnt, e);
        measuring = 1'b0;
      end else if (mcnt > 3000) begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(1'b0, t, mcnt, e);
        measuring = 1'b0;
      end
    end
  end

  // R2 R3: start pulse arms the latch and gates the drive
  task automatic startCycle();
    @(negedge clk);
    cycleStart = 1'b1;
    @(negedge clk);
    check(pwmDel == 1'b1, "R2", pwmDel, 1);
    check(auxDrv == 1'b0, "R3", auxDrv, 0);
    cycleStart = 1'b0;
    @(negedge clk);
    check(auxDrv == 1'b1, "R3", auxDrv, 1);
  endtask

  // Driver: drops pwmIn and pushes the expected edge count
  task automatic fallAndMeasure(input int expv, input string tag);
    @(negedge clk);
    #1;
    pwmIn = 1'b0;
    expQ.push_back(expv);
    tagQ.push_back(tag);
    mcnt = 0;
    measuring = 1'b1;
    while (measuring) @(negedge clk);
  endtask

  task automatic runDelay(input int d, input int p, input string tag);
    demand = 8'(d);
    prescale = 8'(p);
    pwmIn = 1'b1;
    startCycle();
    repeat (4) @(negedge clk);
    fallAndMeasure(3 + d * (p + 1), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pwmDel == 1'b0, "R1", pwmDel, 0);
    check(auxDrv == 1'b0, "R1", auxDrv, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(pwmDel == 1'b0, "R1", pwmDel, 0);

    runDelay(0, 0, "R5");
    runDelay(0, 7, "R5");
    runDelay(1, 0, "R6");
    runDelay(5, 0, "R6");
    runDelay(200, 0, "R6");
    runDelay(5, 3, "R7");
    runDelay(1, 255, "R7");
    runDelay(255, 1, "R7");

    // R8: abandon a long delay with a new start pulse
    demand = 8'd100;
    prescale = 8'd0;
    pwmIn = 1'b1;
    startCycle();
    repeat (4) @(negedge clk);
    pwmIn = 1'b0;
    repeat (20) @(negedge clk);
    check(pwmDel == 1'b1, "R6", pwmDel, 1);
    startCycle();
    repeat (150) @(negedge clk);
    check(pwmDel == 1'b1, "R8", pwmDel, 1);
    demand = 8'd4;
    pwmIn = 1'b1;
    repeat (4) @(negedge clk);
    check(pwmDel == 1'b1, "R8", pwmDel, 1);
    fallAndMeasure(7, "R8");

    repeat (4) @(negedge clk);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule